// File: doc/BRIEF.md
# Absolute Address Bit Predictor

A cache that is indexed with address bits lying above the 4 KB page offset needs four translated bits before the TLB has produced them. This block guesses those four bits from history, so the cache lookup can start in parallel with translation. It keeps two independent 256-entry history tables of 4-bit guesses: one for operand accesses and one for instruction fetch.

The operand-side index is a fast XOR hash of the base register, the index register and the displacement. It is formed in the decode cycle and read from the table one cycle later. When a base or index register is still waiting for a load or load-address result, the forwarded value replaces the register-file value in the hash. The fetch-side index is taken from one selected address: the sequential instruction address, a predicted branch target, or the single register that a surprise branch names. When the real translated bits come back, the block compares them with the last guess from that side. On a mismatch it raises a one-cycle mispredict flag and rewrites the table entry that was used.

Top module: `abs_bit_predictor`

## Requirements
- R1: After reset every entry of both tables holds the low four bits of its own 8-bit index. Both prediction-valid outputs and both mispredict outputs are low.
- R2: The operand index is F(B) ^ F(X) ^ disp[11:4], where F(v) = v[19:12] ^ v[27:20]. A register whose use flag is low contributes zero. The 4-bit prediction is the operand table entry at that index.
- R3: When a register's forward flag is set, its forwarded value takes the place of its register-file value in the operand hash.
- R4: The fetch index is F(A). A is chosen by the 2-bit source code: 0 selects the instruction address, 1 the predicted target, 2 the base register and 3 the index register. The three inputs that are not selected have no effect.
- R5: Each side's prediction-valid output is high in exactly the cycle after its request input was high. The prediction bits are valid in that same cycle.
- R6: A training pulse compares the returned bits with the bits most recently predicted on that side. The side's mispredict output is high in the next cycle exactly when they differ, and it is never high without a training pulse in the cycle before.
- R7: On a mismatch, the table entry at the recorded index is overwritten with the returned bits. On a match, the entry is left unchanged.
- R8: Training on one side never changes the other side's table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_dec_vld | input | 1 | Operand request in decode cycle |
| op_base_use | input | 1 | Instruction uses a base register |
| op_base_gr | input | 32 | Base register-file value |
| op_base_fwd | input | 1 | Base register has a pending forwarded value |
| op_base_fwdval | input | 32 | Forwarded base value |
| op_idx_use | input | 1 | Instruction uses an index register |
| op_idx_gr | input | 32 | Index register-file value |
| op_idx_fwd | input | 1 | Index register has a pending forwarded value |
| op_idx_fwdval | input | 32 | Forwarded index value |
| op_disp | input | 12 | Displacement field |
| op_pred_vld | output | 1 | Operand prediction valid |
| op_pred_bits | output | 4 | Predicted translated bits 15:12 |
| op_trn_vld | input | 1 | Operand translation result valid |
| op_trn_bits | input | 4 | Real translated bits, operand side |
| op_mispred | output | 1 | Operand mispredict flag |
| if_req_vld | input | 1 | Fetch request |
| if_src | input | 2 | Fetch index source select |
| if_ia | input | 32 | Current instruction address |
| if_tgt | input | 32 | Predicted branch target |
| if_base | input | 32 | Surprise branch base register |
| if_index | input | 32 | Surprise branch index register |
| if_pred_vld | output | 1 | Fetch prediction valid |
| if_pred_bits | output | 4 | Predicted bits, fetch side |
| if_trn_vld | input | 1 | Fetch translation result valid |
| if_trn_bits | input | 4 | Real translated bits, fetch side |
| if_mispred | output | 1 | Fetch mispredict flag |

## Verification
A prediction is due in the cycle after its request: one register holds the hashed index, and the table read is combinational from it. The bench drives inputs at a falling edge, lets one rising edge pass and samples at the next falling edge. Mispredict flags and table updates come one edge after the training pulse. The bench therefore samples the flag at the falling edge after that rising edge, and it only sees the rewritten entry through a later request. Each request is followed by one more edge before any training, so that the design's recorded index and bits match the bench's model.

// File: rtl/abs_bit_predictor.sv
module abs_bit_predictor #(
  parameter int AW  = 32,
  parameter int DW  = 12,
  parameter int PB  = 4,
  parameter int IW  = 8,
  parameter int PGB = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_dec_vld,
  input  logic          op_base_use,
  input  logic [AW-1:0] op_base_gr,
  input  logic          op_base_fwd,
  input  logic [AW-1:0] op_base_fwdval,
  input  logic          op_idx_use,
  input  logic [AW-1:0] op_idx_gr,
  input  logic          op_idx_fwd,
  input  logic [AW-1:0] op_idx_fwdval,
  input  logic [DW-1:0] op_disp,
  output logic          op_pred_vld,
  output logic [PB-1:0] op_pred_bits,
  input  logic          op_trn_vld,
  input  logic [PB-1:0] op_trn_bits,
  output logic          op_mispred,
  input  logic          if_req_vld,
  input  logic [1:0]    if_src,
  input  logic [AW-1:0] if_ia,
  input  logic [AW-1:0] if_tgt,
  input  logic [AW-1:0] if_base,
  input  logic [AW-1:0] if_index,
  output logic          if_pred_vld,
  output logic [PB-1:0] if_pred_bits,
  input  logic          if_trn_vld,
  input  logic [PB-1:0] if_trn_bits,
  output logic          if_mispred
);
  localparam int ENT = 1 << IW;

  function automatic logic [IW-1:0] fold(input logic [AW-1:0] v);
    return v[PGB +: IW] ^ v[PGB+IW +: IW];
  endfunction

  logic [AW-1:0] op_b, op_x, if_a;
  logic [IW-1:0] op_hash, if_hash;

  assign op_b = !op_base_use ? '0 : (op_base_fwd ? op_base_fwdval : op_base_gr);
  assign op_x = !op_idx_use  ? '0 : (op_idx_fwd  ? op_idx_fwdval  : op_idx_gr);
  assign op_hash = fold(op_b) ^ fold(op_x) ^ op_disp[DW-1 -: IW];

  always_comb begin
    case (if_src)
      2'd0:    if_a = if_ia;
      2'd1:    if_a = if_tgt;
      2'd2:    if_a = if_base;
      default: if_a = if_index;
    endcase
  end
  assign if_hash = fold(if_a);

  logic [PB-1:0] op_tbl [ENT];
  logic [PB-1:0] if_tbl [ENT];
  logic [IW-1:0] op_idx_q, if_idx_q, op_rec_idx, if_rec_idx;
  logic [PB-1:0] op_rec_bits, if_rec_bits;
  logic          op_vld_q, if_vld_q, op_mis_q, if_mis_q;
  logic          op_diff, if_diff;

  assign op_pred_vld  = op_vld_q;
  assign if_pred_vld  = if_vld_q;
  assign op_pred_bits = op_tbl[op_idx_q];
  assign if_pred_bits = if_tbl[if_idx_q];
  assign op_mispred   = op_mis_q;
  assign if_mispred   = if_mis_q;
  assign op_diff = op_trn_vld && (op_trn_bits != op_rec_bits);
  assign if_diff = if_trn_vld && (if_trn_bits != if_rec_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) op_tbl[i] <= PB'(i);
      op_vld_q    <= 1'b0;
      op_idx_q    <= '0;
      op_rec_idx  <= '0;
      op_rec_bits <= '0;
      op_mis_q    <= 1'b0;
    end else begin
      op_vld_q <= op_dec_vld;
      if (op_dec_vld) op_idx_q <= op_hash;
      if (op_vld_q) begin
        op_rec_idx  <= op_idx_q;
        op_rec_bits <= op_pred_bits;
      end
      op_mis_q <= op_diff;
      if (op_diff) op_tbl[op_rec_idx] <= op_trn_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) if_tbl[i] <= PB'(i);
      if_vld_q    <= 1'b0;
      if_idx_q    <= '0;
      if_rec_idx  <= '0;
      if_rec_bits <= '0;
      if_mis_q    <= 1'b0;
    end else begin
      if_vld_q <= if_req_vld;
      if (if_req_vld) if_idx_q <= if_hash;
      if (if_vld_q) begin
        if_rec_idx  <= if_idx_q;
        if_rec_bits <= if_pred_bits;
      end
      if_mis_q <= if_diff;
      if (if_diff) if_tbl[if_rec_idx] <= if_trn_bits;
    end
  end
endmodule

// File: rtl/abs_bit_predictor_chk.sv
module abs_bit_predictor_chk (
  input logic clk,
  input logic rst_n,
  input logic op_dec_vld,
  input logic op_pred_vld,
  input logic op_trn_vld,
  input logic op_mispred,
  input logic if_req_vld,
  input logic if_pred_vld,
  input logic if_trn_vld,
  input logic if_mispred
);
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!op_pred_vld && !if_pred_vld && !op_mispred && !if_mispred)
        else $error("reset outputs not quiet");
    end
  end

  p_op_pred_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_dec_vld |=> op_pred_vld);
  p_op_pred_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !op_dec_vld |=> !op_pred_vld);
  p_if_pred_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    if_req_vld |=> if_pred_vld);
  p_if_pred_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !if_req_vld |=> !if_pred_vld);
  p_op_mis_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !op_trn_vld |=> !op_mispred);
  p_if_mis_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !if_trn_vld |=> !if_mispred);
endmodule

bind abs_bit_predictor abs_bit_predictor_chk u_chk (.*);

// File: tb/test_abs_bit_predictor.sv
`timescale 1ns/1ps
module test_abs_bit_predictor;
  logic clk = 0, rst_n = 0;
  logic op_dec_vld = 0, op_base_use = 0, op_base_fwd = 0, op_idx_use = 0, op_idx_fwd = 0;
  logic [31:0] op_base_gr = 0, op_base_fwdval = 0, op_idx_gr = 0, op_idx_fwdval = 0;
  logic [11:0] op_disp = 0;
  logic op_pred_vld, op_mispred, if_pred_vld, if_mispred;
  logic [3:0] op_pred_bits, if_pred_bits;
  logic op_trn_vld = 0, if_trn_vld = 0, if_req_vld = 0;
  logic [3:0] op_trn_bits = 0, if_trn_bits = 0;
  logic [1:0] if_src = 0;
  logic [31:0] if_ia = 0, if_tgt = 0, if_base = 0, if_index = 0;

  always #2.5 clk = ~clk;

  abs_bit_predictor i_abs_bit_predictor (.*);

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_op [256];
  logic [3:0] m_if [256];
  logic [7:0] op_ridx = 0, if_ridx = 0;
  logic [3:0] op_rbits = 0, if_rbits = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mf(input logic [31:0] v);
    return v[27:20] ^ v[19:12];
  endfunction

  task automatic do_op(input bit bu, input logic [31:0] b, input bit bf, input logic [31:0] bfv,
                       input bit xu, input logic [31:0] x, input bit xf, input logic [31:0] xfv,
                       input logic [11:0] d, input string tag);
    logic [31:0] be, xe;
    logic [7:0] h;
    be = bu ? (bf ? bfv : b) : 32'd0;
    xe = xu ? (xf ? xfv : x) : 32'd0;
    h = mf(be) ^ mf(xe) ^ d[11:4];
    @(negedge clk);
    op_dec_vld = 1; op_base_use = bu; op_base_gr = b; op_base_fwd = bf; op_base_fwdval = bfv;
    op_idx_use = xu; op_idx_gr = x; op_idx_fwd = xf; op_idx_fwdval = xfv; op_disp = d;
    @(posedge clk);
    @(negedge clk);
    op_dec_vld = 0;
    chk(op_pred_vld == 1'b1, "R5 op pred valid", int'(op_pred_vld), 1);
    chk(op_pred_bits == m_op[h], tag, int'(op_pred_bits), int'(m_op[h]));
    op_ridx = h; op_rbits = m_op[h];
    @(posedge clk);
  endtask

  task automatic do_if(input logic [1:0] s, input logic [31:0] ia, input logic [31:0] tg,
                       input logic [31:0] bs, input logic [31:0] ix, input string tag);
    logic [7:0] h;
    h = (s == 0) ? mf(ia) : (s == 1) ? mf(tg) : (s == 2) ? mf(bs) : mf(ix);
    @(negedge clk);
    if_req_vld = 1; if_src = s; if_ia = ia; if_tgt = tg; if_base = bs; if_index = ix;
    @(posedge clk);
    @(negedge clk);
    if_req_vld = 0;
    chk(if_pred_vld == 1'b1, "R5 if pred valid", int'(if_pred_vld), 1);
    chk(if_pred_bits == m_if[h], tag, int'(if_pred_bits), int'(m_if[h]));
    if_ridx = h; if_rbits = m_if[h];
    @(posedge clk);
  endtask

  task automatic trn_op(input logic [3:0] v);
    bit e;
    e = (v != op_rbits);
    @(negedge clk);
    op_trn_vld = 1; op_trn_bits = v;
    @(posedge clk);
    @(negedge clk);
    op_trn_vld = 0;
    chk(op_mispred == e, "R6 op mispredict", int'(op_mispred), int'(e));
    chk(op_pred_vld == 1'b0, "R5 op idle", int'(op_pred_vld), 0);
    if (e) m_op[op_ridx] = v;
  endtask

  task automatic trn_if(input logic [3:0] v);
    bit e;
    e = (v != if_rbits);
    @(negedge clk);
    if_trn_vld = 1; if_trn_bits = v;
    @(posedge clk);
    @(negedge clk);
    if_trn_vld = 0;
    chk(if_mispred == e, "R6 if mispredict", int'(if_mispred), int'(e));
    chk(if_pred_vld == 1'b0, "R5 if idle", int'(if_pred_vld), 0);
    if (e) m_if[if_ridx] = v;
  endtask

  bit done = 0;
  initial begin
    #(100000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pool [4];
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int i = 0; i < 256; i++) begin m_op[i] = 4'(i); m_if[i] = 4'(i); end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!op_pred_vld && !if_pred_vld, "R1 reset valid low", int'(op_pred_vld), 0);
    chk(!op_mispred && !if_mispred, "R1 reset mispredict low", int'(op_mispred), 0);
    rst_n = 1;

    do_op(1, 32'h0003_5000, 0, 0, 0, 0, 0, 0, 12'h000, "R1 R2 op reset entry base only");
    do_op(1, 32'h0A1B_C000, 0, 0, 1, 32'h0070_3000, 0, 0, 12'h5A0, "R2 op base index disp hash");
    do_op(0, 32'hFFFF_F000, 0, 0, 0, 32'h1234_5000, 0, 0, 12'h9C0, "R2 unused regs contribute zero");
    do_op(1, 32'h0000_0000, 1, 32'h00F0_E000, 0, 0, 0, 0, 12'h000, "R3 base forward replaces gr");
    do_op(1, 32'h0011_1000, 0, 0, 1, 32'h0F00_0000, 1, 32'h0000_7000, 12'h010, "R3 index forward replaces gr");
    do_op(1, 32'h0011_1000, 1, 32'h0022_2000, 1, 32'h0033_3000, 1, 32'h0044_4000, 12'hFF0, "R3 both forwards");

    do_if(0, 32'h0004_2000, 32'hFFFF_F000, 32'hFFFF_F000, 32'hFFFF_F000, "R4 src0 instruction address");
    do_if(1, 32'hFFFF_F000, 32'h0123_9000, 32'hFFFF_F000, 32'hFFFF_F000, "R4 src1 predicted target");
    do_if(2, 32'h0, 32'h0, 32'h00C0_5000, 32'h0AAA_A000, "R4 src2 base only");
    do_if(2, 32'h0, 32'h0, 32'h00C0_5000, 32'h0555_5000, "R4 src2 index ignored");
    do_if(3, 32'h0F0F_0000, 32'h0, 32'h0777_7000, 32'h0008_B000, "R4 src3 index only");

    do_op(1, 32'h0000_7000, 0, 0, 0, 0, 0, 0, 12'h000, "R2 op before train");
    trn_op(4'hC);
    do_op(1, 32'h0000_7000, 0, 0, 0, 0, 0, 0, 12'h000, "R7 op entry rewritten");
    trn_op(4'hC);
    do_op(1, 32'h0000_7000, 0, 0, 0, 0, 0, 0, 12'h000, "R7 matching train keeps entry");
    do_if(0, 32'h0000_7000, 0, 0, 0, "R8 if table untouched by op training");
    trn_if(4'h3);
    do_if(0, 32'h0000_7000, 0, 0, 0, "R7 if entry rewritten");
    do_op(1, 32'h0000_7000, 0, 0, 0, 0, 0, 0, 12'h000, "R8 op table untouched by if training");

    for (int k = 0; k < 4; k++) pool[k] = $urandom() & 32'h0FFF_F000;
    for (int it = 0; it < 600; it++) begin
      if ($urandom_range(1, 0) == 0) begin
        do_op(1'($urandom()), pool[$urandom_range(3, 0)], 1'($urandom()), pool[$urandom_range(3, 0)],
              1'($urandom()), pool[$urandom_range(3, 0)], 1'($urandom()), pool[$urandom_range(3, 0)],
              12'($urandom_range(3, 0) << 4), "R2 R3 op random");
        if ($urandom_range(2, 0) != 0) trn_op(4'($urandom()));
      end else begin
        do_if(2'($urandom()), pool[$urandom_range(3, 0)], pool[$urandom_range(3, 0)],
              pool[$urandom_range(3, 0)], pool[$urandom_range(3, 0)], "R4 R7 if random");
        if ($urandom_range(2, 0) != 0) trn_if(4'($urandom()));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule